// File: doc/BRIEF.md
# Capture/Compare Timer with Overflow Tracking

This block is a parameterised up-counter (16 bits by default) that steps only on cycles where a single-cycle count enable is high. Three counting modes are available. In free-running mode the counter wraps at all-ones. In match-clear mode it returns to zero on the step after it equals channel 0's register. In edge-clear mode it returns to zero on the first step after a selected edge on a dedicated clear pin.

Each of `NUM_CC` channel registers works either as a compare register or as a capture register. As a compare register, a match raises a one-cycle interrupt. As a capture register, a selected edge on the channel's pin latches the counter value and raises the interrupt. A sticky overflow flag records every step from all-ones to zero. Software can clear that flag, but a clear issued before the counter has stepped again after the overflow is overridden.

A register port carries configuration, compare loads, capture reads and status clears. The port also reports reads whose data collided with a capture. Writes to a compare register that land in the same cycle as a match on that register are also reported.

Top module: `tmr_capcmp`

## Requirements
- R1: After reset the counter, control, status and all channel registers read 0, and every interrupt output and the overflow flag are low.
- R2: The counter changes only in cycles with `cnt_en_i` high. It adds 1 per step, and in free-running mode (control bits [1:0] = 0, also used for code 3) it wraps from all-ones to 0.
- R3: In match-clear mode (control bits [1:0] = 1), a step taken while the counter equals channel 0's register loads 0 instead of incrementing.
- R4: In edge-clear mode (control bits [1:0] = 2), a valid edge on `clr_pin_i` makes the next count step load 0. The edge is selected by control bits [3:2]: 0 none, 1 rising, 2 falling, 3 both. An edge that is not selected has no effect on the count.
- R5: Every step from all-ones to 0, in any mode, sets the overflow flag (status bit 0, also on `ovf_flag_o`) and pulses `irq_ovf_o` for one cycle in the cycle after that step.
- R6: The overflow flag is sticky. Writing 0 to status bit 0 clears it only if at least one count step has completed since the last overflow and the write cycle is not itself an overflow step. Otherwise the flag stays 1.
- R7: A channel in compare mode pulses its bit of `irq_cc_o` for one cycle after a step taken while the counter equals its register. When channel 0 holds all-ones, its pulse coincides with the overflow pulse.
- R8: A channel in capture mode (control bit 4+k set) latches the counter into its register and pulses its interrupt on a valid edge of `cap_pin_i[k]`. The edge is selected by control bits [4+NUM_CC+2k+1 : 4+NUM_CC+2k], with the same encoding as R4. Inputs pass a two-flop synchroniser, so an edge takes effect on the third clock edge after the pin changes.
- R9: A read of a channel register (address 4+k) in the cycle a capture lands on it returns the previous value and raises `rd_invalid_o`. The capture still takes effect. At all other times `rd_invalid_o` is low.
- R10: A write to a compare-mode channel register in the same cycle as a match on it suppresses that match's interrupt (and its clear effect in match-clear mode) and sets status bit 1. Writing 0 to status bit 1 clears it. The written value is stored.
- R11: Register map: address 0 control, 1 status, 2 counter (read-only), 4+k channel k. Reads of other addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cnt_en_i | input | 1 | Count step enable, one cycle per step |
| clr_pin_i | input | 1 | External clear input, asynchronous |
| cap_pin_i | input | NUM_CC | Capture inputs, one per channel, asynchronous |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | DW | Write data |
| reg_rdata_o | output | DW | Read data, combinational from current state |
| rd_invalid_o | output | 1 | Current read collided with a capture |
| irq_cc_o | output | NUM_CC | Per-channel match/capture interrupt pulses |
| irq_ovf_o | output | 1 | Overflow interrupt pulse |
| ovf_flag_o | output | 1 | Sticky overflow flag |

## Verification
The bench builds the block with `CW = 8`, `NUM_CC = 2` and `DW = 16`. The narrow counter puts the all-ones wrap 256 steps away, so overflow, the overridden clear and the coincident channel-0 match are all reached directly. With two channels, one can capture while the other compares, and the field offsets that depend on the channel count are exercised. A vector table covers free-running and match-clear counts with several compare values, including 0 and a count that wraps. Directed tests then place a read, a write or a clear in the exact cycle of a capture, a match or an overflow.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    MODE_FREE      = 2'd0,
    MODE_CLR_MATCH = 2'd1,
    MODE_CLR_EDGE  = 2'd2,
    MODE_RSVD      = 2'd3
  } mode_e;

  typedef enum logic [1:0] {
    EDGE_NONE = 2'd0,
    EDGE_RISE = 2'd1,
    EDGE_FALL = 2'd2,
    EDGE_BOTH = 2'd3
  } edge_sel_e;

  localparam logic [2:0] ADDR_CTRL   = 3'd0;
  localparam logic [2:0] ADDR_STATUS = 3'd1;
  localparam logic [2:0] ADDR_COUNT  = 3'd2;
  localparam logic [2:0] ADDR_CC0    = 3'd4;
endpackage

// File: rtl/tmr_edge_det.sv
module tmr_edge_det
  import tmr_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      pin_i,
  input  edge_sel_e sel_i,
  output logic      edge_o
);
  logic [2:0] sh_q;
  logic       rise, fall;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[1:0], pin_i};
  end

  assign rise = sh_q[1] & ~sh_q[2];
  assign fall = ~sh_q[1] & sh_q[2];

  always_comb begin
    unique case (sel_i)
      EDGE_RISE: edge_o = rise;
      EDGE_FALL: edge_o = fall;
      EDGE_BOTH: edge_o = rise | fall;
      default:   edge_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter
  import tmr_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cnt_en_i,
  input  mode_e         mode_i,
  input  logic          match_i,
  input  logic          edge_i,
  output logic [CW-1:0] cnt_o,
  output logic          wrap_o
);
  localparam logic [CW-1:0] CNT_MAX = {CW{1'b1}};

  logic [CW-1:0] cnt_q;
  logic          pend_q;
  logic          clr_req;

  // edge-clear waits for the next count step
  always_comb begin
    unique case (mode_i)
      MODE_CLR_MATCH: clr_req = match_i;
      MODE_CLR_EDGE:  clr_req = pend_q;
      default:        clr_req = 1'b0;
    endcase
  end

  assign wrap_o = cnt_en_i & (cnt_q == CNT_MAX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      if (cnt_en_i) cnt_q <= clr_req ? '0 : cnt_q + 1'b1;
      pend_q <= (edge_i & (mode_i == MODE_CLR_EDGE)) | (pend_q & ~cnt_en_i);
    end
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/tmr_ccu.sv
module tmr_ccu #(
  parameter int CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cap_mode_i,
  input  logic          cap_evt_i,
  input  logic          cnt_en_i,
  input  logic [CW-1:0] cnt_i,
  input  logic          wr_i,
  input  logic [CW-1:0] wdata_i,
  output logic [CW-1:0] val_o,
  output logic          match_o,
  output logic          cap_o,
  output logic          conflict_o,
  output logic          irq_o
);
  logic [CW-1:0] val_q;
  logic          irq_q;
  logic          raw_match;

  assign raw_match  = ~cap_mode_i & cnt_en_i & (cnt_i == val_q);
  assign conflict_o = raw_match & wr_i;
  assign match_o    = raw_match & ~wr_i;
  assign cap_o      = cap_mode_i & cap_evt_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      val_q <= '0;
      irq_q <= 1'b0;
    end else begin
      if (cap_o)     val_q <= cnt_i;   // capture beats software write
      else if (wr_i) val_q <= wdata_i;
      irq_q <= match_o | cap_o;
    end
  end

  assign val_o = val_q;
  assign irq_o = irq_q;
endmodule

// File: rtl/tmr_capcmp.sv
module tmr_capcmp
  import tmr_pkg::*;
#(
  parameter int CW     = 16,
  parameter int NUM_CC = 2,
  parameter int DW     = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cnt_en_i,
  input  logic              clr_pin_i,
  input  logic [NUM_CC-1:0] cap_pin_i,
  input  logic              reg_we_i,
  input  logic              reg_re_i,
  input  logic [2:0]        reg_addr_i,
  input  logic [DW-1:0]     reg_wdata_i,
  output logic [DW-1:0]     reg_rdata_o,
  output logic              rd_invalid_o,
  output logic [NUM_CC-1:0] irq_cc_o,
  output logic              irq_ovf_o,
  output logic              ovf_flag_o
);
  localparam int CTRL_W  = 4 + 3 * NUM_CC;
  localparam int SEL_LSB = 4 + NUM_CC;

  logic [CTRL_W-1:0] ctrl_q;
  logic              ovf_q, conf_q, ovf_win_q, irq_ovf_q;
  mode_e             mode;
  logic [CW-1:0]     cnt;
  logic              wrap, clr_edge;
  logic              wr_ctrl, wr_status;
  logic [CW-1:0]     cc_val [NUM_CC];
  logic [NUM_CC-1:0] cc_match, cc_cap, cc_conf, cc_wr;
  logic              unused_wdata;

  assign mode      = mode_e'(ctrl_q[1:0]);
  assign wr_ctrl   = reg_we_i & (reg_addr_i == ADDR_CTRL);
  assign wr_status = reg_we_i & (reg_addr_i == ADDR_STATUS);
  assign unused_wdata = ^reg_wdata_i;

  tmr_edge_det u_clr_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_i  (clr_pin_i),
    .sel_i  (edge_sel_e'(ctrl_q[3:2])),
    .edge_o (clr_edge)
  );

  tmr_counter #(.CW(CW)) u_counter (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cnt_en_i (cnt_en_i),
    .mode_i   (mode),
    .match_i  (cc_match[0]),
    .edge_i   (clr_edge),
    .cnt_o    (cnt),
    .wrap_o   (wrap)
  );

  for (genvar k = 0; k < NUM_CC; k++) begin : g_ch
    logic cap_edge;

    assign cc_wr[k] = reg_we_i & (reg_addr_i == 3'(32'(ADDR_CC0) + k));

    tmr_edge_det u_cap_edge (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .pin_i  (cap_pin_i[k]),
      .sel_i  (edge_sel_e'(ctrl_q[SEL_LSB+2*k +: 2])),
      .edge_o (cap_edge)
    );

    tmr_ccu #(.CW(CW)) u_ccu (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .cap_mode_i (ctrl_q[4+k]),
      .cap_evt_i  (cap_edge),
      .cnt_en_i   (cnt_en_i),
      .cnt_i      (cnt),
      .wr_i       (cc_wr[k]),
      .wdata_i    (reg_wdata_i[CW-1:0]),
      .val_o      (cc_val[k]),
      .match_o    (cc_match[k]),
      .cap_o      (cc_cap[k]),
      .conflict_o (cc_conf[k]),
      .irq_o      (irq_cc_o[k])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q    <= '0;
      ovf_q     <= 1'b0;
      ovf_win_q <= 1'b0;
      conf_q    <= 1'b0;
      irq_ovf_q <= 1'b0;
    end else begin
      if (wr_ctrl) ctrl_q <= reg_wdata_i[CTRL_W-1:0];
      // clear honoured only once a step has followed the overflow
      if (wrap)                                      ovf_q <= 1'b1;
      else if (wr_status & ~reg_wdata_i[0] & ~ovf_win_q) ovf_q <= 1'b0;
      ovf_win_q <= wrap | (ovf_win_q & ~cnt_en_i);
      if (|cc_conf)                        conf_q <= 1'b1;
      else if (wr_status & ~reg_wdata_i[1]) conf_q <= 1'b0;
      irq_ovf_q <= wrap;
    end
  end

  always_comb begin
    reg_rdata_o  = '0;
    rd_invalid_o = 1'b0;
    unique case (reg_addr_i)
      ADDR_CTRL:   reg_rdata_o = DW'(ctrl_q);
      ADDR_STATUS: reg_rdata_o = DW'({conf_q, ovf_q});
      ADDR_COUNT:  reg_rdata_o = DW'(cnt);
      default: begin
        for (int k = 0; k < NUM_CC; k++) begin
          if (reg_addr_i == 3'(32'(ADDR_CC0) + k)) begin
            reg_rdata_o  = DW'(cc_val[k]);
            rd_invalid_o = reg_re_i & cc_cap[k];
          end
        end
      end
    endcase
  end

  assign irq_ovf_o  = irq_ovf_q;
  assign ovf_flag_o = ovf_q;
endmodule

// File: rtl/tmr_capcmp_chk.sv
module tmr_capcmp_chk #(
  parameter int CW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          cnt_en_i,
  input logic [CW-1:0] cnt_i,
  input logic          reg_we_i,
  input logic          reg_re_i,
  input logic [2:0]    reg_addr_i,
  input logic          clr_bit_i,
  input logic          rd_invalid_o,
  input logic          irq_ovf_o,
  input logic          ovf_flag_o
);
  // R2
  cnt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cnt_en_i |=> $stable(cnt_i));
  // R2
  cnt_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_en_i && (&cnt_i)) |=> (cnt_i == '0));
  // R5
  ovf_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_en_i && (&cnt_i)) |=> (ovf_flag_o && irq_ovf_o));
  // R5
  ovf_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_ovf_o |=> !irq_ovf_o);
  // R6
  ovf_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_flag_o && !(reg_we_i && reg_addr_i == 3'd1 && !clr_bit_i)) |=> ovf_flag_o);
  // R9
  rd_inv_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_invalid_o |-> reg_re_i);
endmodule

bind tmr_capcmp tmr_capcmp_chk #(.CW(CW)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cnt_en_i     (cnt_en_i),
  .cnt_i        (cnt),
  .reg_we_i     (reg_we_i),
  .reg_re_i     (reg_re_i),
  .reg_addr_i   (reg_addr_i),
  .clr_bit_i    (reg_wdata_i[0]),
  .rd_invalid_o (rd_invalid_o),
  .irq_ovf_o    (irq_ovf_o),
  .ovf_flag_o   (ovf_flag_o)
);

// File: tb/tmr_capcmp_tb.sv
module tmr_capcmp_tb;
  localparam int CW = 8;
  localparam int NUM_CC = 2;
  localparam int DW = 16;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              en = 1'b0;
  logic              clr_pin = 1'b0;
  logic [NUM_CC-1:0] cap_pin = '0;
  logic              we = 1'b0, re = 1'b0;
  logic [2:0]        addr = '0;
  logic [DW-1:0]     wdata = '0;
  logic [DW-1:0]     rdata;
  logic              rd_inv, irq_ovf, ovf_flag;
  logic [NUM_CC-1:0] irq_cc;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  tmr_capcmp #(.CW(CW), .NUM_CC(NUM_CC), .DW(DW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cnt_en_i(en), .clr_pin_i(clr_pin),
    .cap_pin_i(cap_pin), .reg_we_i(we), .reg_re_i(re), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .rd_invalid_o(rd_inv),
    .irq_cc_o(irq_cc), .irq_ovf_o(irq_ovf), .ovf_flag_o(ovf_flag)
  );

  typedef struct packed {
    logic [1:0]  mode;
    logic [7:0]  cc0;
    logic [9:0]  steps;
    logic [15:0] exp;
  } vec_t;

  localparam vec_t VECS [7] = '{
    '{2'd0, 8'd5, 10'd8,   16'd8},
    '{2'd0, 8'd0, 10'd20,  16'd20},
    '{2'd0, 8'd9, 10'd300, 16'd44},
    '{2'd1, 8'd5, 10'd8,   16'd2},
    '{2'd1, 8'd3, 10'd4,   16'd0},
    '{2'd1, 8'd0, 10'd3,   16'd0},
    '{2'd1, 8'd9, 10'd25,  16'd5}
  };

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; en = 1'b0; we = 1'b0; re = 1'b0; clr_pin = 1'b0; cap_pin = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d, output logic inv);
    @(negedge clk);
    re = 1'b1; addr = a;
    #1;
    d = rdata; inv = rd_inv;
    @(negedge clk);
    re = 1'b0;
  endtask

  task automatic run(input int n);
    @(negedge clk);
    en = 1'b1;
    repeat (n) @(negedge clk);
    en = 1'b0;
  endtask

  task automatic step1(output logic [1:0] icc, output logic iovf);
    @(negedge clk);
    en = 1'b1;
    @(negedge clk);
    en = 1'b0;
    icc = irq_cc; iovf = irq_ovf;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #(20 * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] d;
    logic        inv;
    logic [1:0]  icc;
    logic        iovf;

    // R1 reset state
    do_reset();
    rd(3'd2, d, inv); chk("R1 count", d, 0);
    rd(3'd1, d, inv); chk("R1 status", d, 0);
    rd(3'd0, d, inv); chk("R1 ctrl", d, 0);
    rd(3'd4, d, inv); chk("R1 cc0", d, 0);
    chk("R1 irq/flag", {irq_cc, irq_ovf, ovf_flag}, 0);

    // R2 R3 vector table
    foreach (VECS[i]) begin
      do_reset();
      wr(3'd0, 16'(VECS[i].mode));
      wr(3'd4, 16'(VECS[i].cc0));
      run(int'(VECS[i].steps));
      rd(3'd2, d, inv);
      chk(VECS[i].mode == 2'd0 ? "R2 free count" : "R3 match clear", d, VECS[i].exp);
    end

    // R2 no change without enable, R11 unmapped read
    repeat (5) @(negedge clk);
    rd(3'd2, d, inv); chk("R2 hold", d, 5);
    rd(3'd3, d, inv); chk("R11 unmapped", d, 0);

    // R5 R6 overflow
    do_reset();
    run(255);
    chk("R5 no flag before wrap", ovf_flag, 0);
    step1(icc, iovf);
    chk("R5 ovf irq", iovf, 1);
    chk("R5 ovf flag", ovf_flag, 1);
    rd(3'd2, d, inv); chk("R2 wrap", d, 0);
    wr(3'd1, 16'd0);
    chk("R6 early clear overridden", ovf_flag, 1);
    run(1);
    wr(3'd1, 16'd0);
    chk("R6 clear after step", ovf_flag, 0);
    run(254);
    @(negedge clk);
    en = 1'b1; we = 1'b1; addr = 3'd1; wdata = 16'd0;
    @(negedge clk);
    en = 1'b0; we = 1'b0;
    chk("R6 clear on overflow step", ovf_flag, 1);

    // R7 channel 0 at all-ones in match-clear mode
    do_reset();
    wr(3'd0, 16'd1);
    wr(3'd4, 16'hFF);
    run(255);
    step1(icc, iovf);
    chk("R7 cc0 with overflow", {icc, iovf}, 3'b011);

    // R7 compare on channel 1
    do_reset();
    wr(3'd5, 16'd3);
    run(3);
    step1(icc, iovf);
    chk("R7 cc1 match", icc, 2'b10);
    step1(icc, iovf);
    chk("R7 pulse ends", icc, 2'b00);

    // R10 write conflict
    do_reset();
    wr(3'd5, 16'd3);
    run(3);
    @(negedge clk);
    en = 1'b1; we = 1'b1; addr = 3'd5; wdata = 16'd9;
    @(negedge clk);
    en = 1'b0; we = 1'b0;
    chk("R10 match suppressed", irq_cc, 2'b00);
    rd(3'd1, d, inv); chk("R10 conflict bit", d, 16'd2);
    rd(3'd5, d, inv); chk("R10 value stored", d, 16'd9);
    wr(3'd1, 16'd0);
    rd(3'd1, d, inv); chk("R10 conflict cleared", d, 0);

    // R4 edge clear
    do_reset();
    wr(3'd0, 16'h06);
    run(7);
    @(negedge clk); clr_pin = 1'b1;
    settle();
    rd(3'd2, d, inv); chk("R4 waits for step", d, 7);
    run(1);
    rd(3'd2, d, inv); chk("R4 rising clears", d, 0);
    run(2);
    @(negedge clk); clr_pin = 1'b0;
    settle();
    run(1);
    rd(3'd2, d, inv); chk("R4 falling ignored", d, 3);
    wr(3'd0, 16'h0A);
    @(negedge clk); clr_pin = 1'b1;
    settle();
    run(1);
    rd(3'd2, d, inv); chk("R4 rising ignored", d, 4);
    @(negedge clk); clr_pin = 1'b0;
    settle();
    run(1);
    rd(3'd2, d, inv); chk("R4 falling clears", d, 0);
    wr(3'd0, 16'h02);
    @(negedge clk); clr_pin = 1'b1;
    settle();
    run(1);
    rd(3'd2, d, inv); chk("R4 none selected", d, 1);

    // R8 capture on channel 1 (bit5 capture, bits[9:8]=rising)
    do_reset();
    wr(3'd0, 16'h120);
    run(6);
    @(negedge clk); cap_pin[1] = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R8 capture irq", irq_cc, 2'b10);
    rd(3'd5, d, inv); chk("R8 captured value", d, 6);
    chk("R9 plain read valid", inv, 0);

    // R9 capture colliding with a read
    run(4);
    @(negedge clk); cap_pin[1] = 1'b0;
    settle();
    @(negedge clk); cap_pin[1] = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    re = 1'b1; addr = 3'd5;
    #1;
    chk("R9 invalid flag", rd_inv, 1);
    chk("R9 old value", rdata, 6);
    @(negedge clk);
    re = 1'b0;
    rd(3'd5, d, inv); chk("R9 capture wins", d, 10);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule